// File: doc/BRIEF.md
# In-band Software Flow Controller

This block sits beside one serial channel and handles software flow control in both directions. On the receive side it looks at every decoded character. Characters that match the programmed "stop" code pause the local transmitter. Characters that match the "go" code resume it. Matched control characters are removed from the receive stream, and every other character is passed on to the receive queue's write port. Either a single character or a two-character sequence can act as the code. A separate detector can flag one chosen character with an interrupt; that character is still stored.

On the transmit side the block sits between the transmit data source and the serializer. It compares the receive queue's fill level with a trigger level. When the level rises above the trigger, it inserts the stop code into the outgoing stream. When the level later falls below the trigger, it inserts the go code. Inserted characters go ahead of waiting data. They are handed over through the same per-character handshake as data, so a frame already in progress is never cut.

Top module: `swflow_ctrl`

## Requirements
- R1: After reset, `fifo_wr` and `spec_flag` are low, the transmitter is not paused and nothing is being inserted. `ser_vld` equals `txd_vld`, `ser_data` equals `txd_data`, and `txd_rdy` equals `ser_rdy`.
- R2: Receive mode codes are 0 = off, 1 = single set one, 2 = single set two, 3 = dual. In mode 1 a received `cfg_xoff1`, and in mode 2 a received `cfg_xoff2`, is not stored and pauses the transmitter. A pause drives `txd_rdy` low from the cycle after the strobe; `ser_vld` is then high only for inserted characters.
- R3: While paused, a received `cfg_xon1` (mode 1) or `cfg_xon2` (mode 2) is not stored and releases the pause from the following cycle.
- R4: In mode 3 the pair `cfg_xoff1` then `cfg_xoff2`, received as consecutive characters, pauses the transmitter. The pair `cfg_xon1` then `cfg_xon2` resumes it. Neither pair is stored. If a first code is followed by any other character, both characters are stored in arrival order and the pause state does not change.
- R5: A character that is stored appears on `fifo_wr`/`fifo_wdata` one cycle after its `rx_vld` strobe. The one exception is a character that breaks a pending dual pair: it appears two cycles after its strobe, right after the released first code. Strobes are at least two cycles apart.
- R6: With `spec_en` high, a received character equal to `cfg_xoff2` is always stored, is never treated as flow control, and sets `spec_flag` from the next cycle. `spec_flag` stays high until a `spec_clr` pulse. A set in the same cycle wins over a clear.
- R7: With transmit mode not 0 and no stop code owed, the stop code is inserted once `rxq_level` is strictly greater than `rxq_trig`. A level equal to the trigger inserts nothing.
- R8: After a stop code has been sent, the go code is inserted once `rxq_level` is strictly less than `rxq_trig`. It is inserted once per stop code. A go code is never inserted without a stop code sent before it.
- R9: While an inserted character is pending, `txd_rdy` is low and `ser_vld`/`ser_data` hold the inserted character until `ser_rdy` accepts it. No data character is lost or repeated across an insertion.
- R10: Transmit mode codes mirror the receive ones. Mode 1 inserts `cfg_xoff1`/`cfg_xon1`. Mode 2 inserts `cfg_xoff2`/`cfg_xon2`. Mode 3 inserts two back-to-back characters: `cfg_xoff1` then `cfg_xoff2`, or `cfg_xon1` then `cfg_xon2`.
- R11: Receive mode 0 stores every character and clears any pause. Transmit mode 0 inserts nothing and forgets an owed go code.
- R12: A pause does not block inserted characters. The stop and go codes still go out while data is held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Decoded receive character strobe |
| rx_char | input | 8 | Decoded receive character |
| fifo_wr | output | 1 | Write strobe toward the receive queue |
| fifo_wdata | output | 8 | Character written to the receive queue |
| rxq_level | input | LVL_W | Receive queue fill level |
| rxq_trig | input | LVL_W | Receive queue trigger level |
| txd_vld | input | 1 | Transmit data character available |
| txd_data | input | 8 | Transmit data character |
| txd_rdy | output | 1 | Transmit data character taken |
| ser_vld | output | 1 | Character offered to the serializer |
| ser_data | output | 8 | Character offered to the serializer |
| ser_rdy | input | 1 | Serializer accepts a character at a frame boundary |
| cfg_xon1 | input | 8 | First go code |
| cfg_xon2 | input | 8 | Second go code |
| cfg_xoff1 | input | 8 | First stop code |
| cfg_xoff2 | input | 8 | Second stop code, also the special character |
| rx_mode | input | 2 | Receive matching mode (0 off, 1 set one, 2 set two, 3 dual) |
| tx_mode | input | 2 | Insertion mode (0 off, 1 set one, 2 set two, 3 dual) |
| spec_en | input | 1 | Special character detect enable |
| spec_clr | input | 1 | Clears the special character flag |
| spec_flag | output | 1 | Special character seen |

## Verification
The bench builds the block with a receive queue depth of 16, so `LVL_W` is 5. This lets it sweep the fill level across the whole range and park it exactly on, one above and one below the trigger within a short run. The code values used are `cfg_xon1`=0x81, `cfg_xon2`=0x82, `cfg_xoff1`=0x83 and `cfg_xoff2`=0x84. Data characters stay below 0x80, so every inserted code can be told apart from data in the captured serializer stream, and gaps or repeats in the data count can be seen.

// File: rtl/swflow_pkg.sv
package swflow_pkg;

    parameter int SWF_CW = 8;

    typedef logic [SWF_CW-1:0] swf_char_t;

    typedef enum logic [1:0] {
        FC_OFF  = 2'd0,
        FC_SET1 = 2'd1,
        FC_SET2 = 2'd2,
        FC_DUAL = 2'd3
    } fc_mode_e;

    typedef enum logic {
        FK_STOP = 1'b0,
        FK_GO   = 1'b1
    } fc_kind_e;

    typedef enum logic [1:0] {
        INJ_IDLE   = 2'd0,
        INJ_FIRST  = 2'd1,
        INJ_SECOND = 2'd2
    } inj_state_e;

    typedef struct packed {
        swf_char_t go1;
        swf_char_t go2;
        swf_char_t stop1;
        swf_char_t stop2;
    } fc_chars_t;

    // Character used for a given mode, kind and position in a sequence.
    function automatic swf_char_t fc_pick(fc_mode_e m, fc_kind_e k,
                                          logic second, fc_chars_t c);
        logic use_two;
        use_two = (m == FC_SET2) || ((m == FC_DUAL) && second);
        if (k == FK_STOP) return use_two ? c.stop2 : c.stop1;
        else              return use_two ? c.go2   : c.go1;
    endfunction

endpackage

// File: rtl/swflow_rx_match.sv
module swflow_rx_match
    import swflow_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_vld,
    input  swf_char_t rx_char,
    input  fc_mode_e  mode,
    input  fc_chars_t chars,
    input  logic      spec_en,
    input  logic      spec_clr,
    output logic      wr_vld,
    output swf_char_t wr_data,
    output logic      paused,
    output logic      spec_flag
);

    logic      hold_vld, n_hold_vld;
    fc_kind_e  hold_kind, n_hold_kind;
    swf_char_t hold_ch, n_hold_ch;
    logic      spill_vld, n_spill;
    swf_char_t spill_ch;
    logic      n_paused;
    logic      emit, set_flag, is_spec, done, flushed;
    swf_char_t emit_ch, stop_lead, go_lead;

    always_comb begin
        is_spec     = spec_en && (rx_char == chars.stop2);
        stop_lead   = fc_pick(mode, FK_STOP, 1'b0, chars);
        go_lead     = fc_pick(mode, FK_GO, 1'b0, chars);
        n_paused    = (mode == FC_OFF) ? 1'b0 : paused;
        n_hold_vld  = (mode == FC_DUAL) ? hold_vld : 1'b0;
        n_hold_kind = hold_kind;
        n_hold_ch   = hold_ch;
        emit        = 1'b0;
        emit_ch     = rx_char;
        n_spill     = 1'b0;
        set_flag    = 1'b0;
        done        = 1'b0;
        flushed     = 1'b0;
        if (rx_vld) begin
            set_flag = is_spec;
            case (mode)
                FC_SET1, FC_SET2: begin
                    if (!is_spec && rx_char == stop_lead)    n_paused = 1'b1;
                    else if (!is_spec && rx_char == go_lead) n_paused = 1'b0;
                    else                                     emit = 1'b1;
                end
                FC_DUAL: begin
                    if (hold_vld) begin
                        if (!is_spec && hold_kind == FK_STOP && rx_char == chars.stop2) begin
                            n_paused   = 1'b1;
                            n_hold_vld = 1'b0;
                            done       = 1'b1;
                        end else if (!is_spec && hold_kind == FK_GO && rx_char == chars.go2) begin
                            n_paused   = 1'b0;
                            n_hold_vld = 1'b0;
                            done       = 1'b1;
                        end else begin
                            // Pair broken: release the held first code now.
                            emit       = 1'b1;
                            emit_ch    = hold_ch;
                            n_hold_vld = 1'b0;
                            flushed    = 1'b1;
                        end
                    end
                    if (!done) begin
                        if (!is_spec && rx_char == chars.stop1) begin
                            n_hold_vld  = 1'b1;
                            n_hold_kind = FK_STOP;
                            n_hold_ch   = rx_char;
                        end else if (!is_spec && rx_char == chars.go1) begin
                            n_hold_vld  = 1'b1;
                            n_hold_kind = FK_GO;
                            n_hold_ch   = rx_char;
                        end else if (flushed) begin
                            n_spill = 1'b1;
                        end else begin
                            emit = 1'b1;
                        end
                    end
                end
                default: emit = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            paused    <= 1'b0;
            hold_vld  <= 1'b0;
            hold_kind <= FK_STOP;
            hold_ch   <= '0;
            spill_vld <= 1'b0;
            spill_ch  <= '0;
            wr_vld    <= 1'b0;
            wr_data   <= '0;
            spec_flag <= 1'b0;
        end else begin
            paused    <= n_paused;
            hold_vld  <= n_hold_vld;
            hold_kind <= n_hold_kind;
            hold_ch   <= n_hold_ch;
            spill_vld <= n_spill;
            spill_ch  <= rx_char;
            wr_vld    <= emit || spill_vld;
            wr_data   <= emit ? emit_ch : spill_ch;
            spec_flag <= set_flag || (spec_flag && !spec_clr);
        end
    end

endmodule

// File: rtl/swflow_tx_inject.sv
module swflow_tx_inject
    import swflow_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  fc_mode_e         mode,
    input  fc_chars_t        chars,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] trig,
    input  logic             ser_rdy,
    output logic             inj_vld,
    output swf_char_t        inj_char
);

    inj_state_e st, n_st;
    fc_kind_e   kind, n_kind;
    logic       owe_go, n_owe_go;
    logic       over, under;

    assign over  = level > trig;
    assign under = level < trig;

    always_comb begin
        n_st     = st;
        n_kind   = kind;
        n_owe_go = owe_go;
        case (st)
            INJ_IDLE: begin
                if (mode == FC_OFF) begin
                    n_owe_go = 1'b0;
                end else if (!owe_go && over) begin
                    n_kind = FK_STOP;
                    n_st   = INJ_FIRST;
                end else if (owe_go && under) begin
                    n_kind = FK_GO;
                    n_st   = INJ_FIRST;
                end
            end
            INJ_FIRST: begin
                if (ser_rdy) begin
                    if (mode == FC_DUAL) begin
                        n_st = INJ_SECOND;
                    end else begin
                        n_st     = INJ_IDLE;
                        n_owe_go = (kind == FK_STOP);
                    end
                end
            end
            INJ_SECOND: begin
                if (ser_rdy) begin
                    n_st     = INJ_IDLE;
                    n_owe_go = (kind == FK_STOP);
                end
            end
            default: n_st = INJ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= INJ_IDLE;
            kind   <= FK_STOP;
            owe_go <= 1'b0;
        end else begin
            st     <= n_st;
            kind   <= n_kind;
            owe_go <= n_owe_go;
        end
    end

    assign inj_vld  = (st != INJ_IDLE);
    assign inj_char = fc_pick(mode, kind, st == INJ_SECOND, chars);

endmodule

// File: rtl/swflow_tx_arb.sv
module swflow_tx_arb
    import swflow_pkg::*;
(
    input  logic      inj_vld,
    input  swf_char_t inj_char,
    input  logic      paused,
    input  logic      txd_vld,
    input  swf_char_t txd_data,
    input  logic      ser_rdy,
    output logic      ser_vld,
    output swf_char_t ser_data,
    output logic      txd_rdy
);

    // Inserted codes win; data flows only when not paused.
    assign ser_vld  = inj_vld || (txd_vld && !paused);
    assign ser_data = inj_vld ? inj_char : txd_data;
    assign txd_rdy  = ser_rdy && !inj_vld && !paused;

endmodule

// File: rtl/swflow_ctrl.sv
module swflow_ctrl
    import swflow_pkg::*;
#(
    parameter  int RXQ_DEPTH = 64,
    localparam int LVL_W     = $clog2(RXQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_vld,
    input  logic [SWF_CW-1:0] rx_char,
    output logic              fifo_wr,
    output logic [SWF_CW-1:0] fifo_wdata,
    input  logic [LVL_W-1:0]  rxq_level,
    input  logic [LVL_W-1:0]  rxq_trig,
    input  logic              txd_vld,
    input  logic [SWF_CW-1:0] txd_data,
    output logic              txd_rdy,
    output logic              ser_vld,
    output logic [SWF_CW-1:0] ser_data,
    input  logic              ser_rdy,
    input  logic [SWF_CW-1:0] cfg_xon1,
    input  logic [SWF_CW-1:0] cfg_xon2,
    input  logic [SWF_CW-1:0] cfg_xoff1,
    input  logic [SWF_CW-1:0] cfg_xoff2,
    input  logic [1:0]        rx_mode,
    input  logic [1:0]        tx_mode,
    input  logic              spec_en,
    input  logic              spec_clr,
    output logic              spec_flag
);

    fc_chars_t chars;
    fc_mode_e  rxm, txm;
    logic      paused;
    logic      inj_vld;
    swf_char_t inj_char;

    assign chars = '{go1: cfg_xon1, go2: cfg_xon2, stop1: cfg_xoff1, stop2: cfg_xoff2};
    assign rxm   = fc_mode_e'(rx_mode);
    assign txm   = fc_mode_e'(tx_mode);

    swflow_rx_match u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_vld    (rx_vld),
        .rx_char   (rx_char),
        .mode      (rxm),
        .chars     (chars),
        .spec_en   (spec_en),
        .spec_clr  (spec_clr),
        .wr_vld    (fifo_wr),
        .wr_data   (fifo_wdata),
        .paused    (paused),
        .spec_flag (spec_flag)
    );

    swflow_tx_inject #(.LVL_W(LVL_W)) u_inj (
        .clk      (clk),
        .rst      (rst),
        .mode     (txm),
        .chars    (chars),
        .level    (rxq_level),
        .trig     (rxq_trig),
        .ser_rdy  (ser_rdy),
        .inj_vld  (inj_vld),
        .inj_char (inj_char)
    );

    swflow_tx_arb u_arb (
        .inj_vld  (inj_vld),
        .inj_char (inj_char),
        .paused   (paused),
        .txd_vld  (txd_vld),
        .txd_data (txd_data),
        .ser_rdy  (ser_rdy),
        .ser_vld  (ser_vld),
        .ser_data (ser_data),
        .txd_rdy  (txd_rdy)
    );

endmodule

// File: rtl/swflow_ctrl_chk.sv
module swflow_ctrl_chk
    import swflow_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rx_vld,
    input logic [SWF_CW-1:0] rx_char,
    input logic [SWF_CW-1:0] cfg_xoff1,
    input logic [SWF_CW-1:0] cfg_xoff2,
    input logic [1:0]        rx_mode,
    input logic [1:0]        tx_mode,
    input logic              spec_en,
    input logic              spec_flag,
    input logic              txd_rdy,
    input logic              ser_vld,
    input logic              ser_rdy,
    input logic [SWF_CW-1:0] ser_data,
    input logic              inj_vld,
    input logic              paused
);

    a_r9_insert_blocks_data: assert property (@(posedge clk) disable iff (rst)
        inj_vld |-> !txd_rdy);

    a_r9_insert_held: assert property (@(posedge clk) disable iff (rst)
        (inj_vld && !ser_rdy) |=> (inj_vld && ser_vld && $stable(ser_data)));

    a_r2_pause_blocks_data: assert property (@(posedge clk) disable iff (rst)
        (paused && !inj_vld) |-> !txd_rdy);

    a_r2_single_stop: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && rx_mode == FC_SET1 && rx_char == cfg_xoff1
         && !(spec_en && rx_char == cfg_xoff2)) |=> paused);

    a_r6_special_flag: assert property (@(posedge clk) disable iff (rst)
        (rx_vld && spec_en && rx_char == cfg_xoff2) |=> spec_flag);

    a_r11_rx_off_unpaused: assert property (@(posedge clk) disable iff (rst)
        (rx_mode == FC_OFF) |=> !paused);

    a_r11_tx_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (tx_mode == FC_OFF && !inj_vld) |=> !inj_vld);

endmodule

bind swflow_ctrl swflow_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_vld    (rx_vld),
    .rx_char   (rx_char),
    .cfg_xoff1 (cfg_xoff1),
    .cfg_xoff2 (cfg_xoff2),
    .rx_mode   (rx_mode),
    .tx_mode   (tx_mode),
    .spec_en   (spec_en),
    .spec_flag (spec_flag),
    .txd_rdy   (txd_rdy),
    .ser_vld   (ser_vld),
    .ser_rdy   (ser_rdy),
    .ser_data  (ser_data),
    .inj_vld   (inj_vld),
    .paused    (paused)
);

// File: tb/swflow_ctrl_test.sv
module swflow_ctrl_test;

    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);
    localparam logic [7:0] XON1 = 8'h81, XON2 = 8'h82, XOFF1 = 8'h83, XOFF2 = 8'h84;

    logic clk = 1'b0, rst = 1'b1;
    logic rx_vld = 1'b0;
    logic [7:0] rx_char = '0;
    logic fifo_wr;
    logic [7:0] fifo_wdata;
    logic [LW-1:0] rxq_level = '0, rxq_trig = '0;
    logic txd_vld = 1'b1;
    logic [7:0] txd_data = '0;
    logic txd_rdy, ser_vld;
    logic [7:0] ser_data;
    logic ser_rdy = 1'b1;
    logic [1:0] rx_mode = 2'd0, tx_mode = 2'd0;
    logic spec_en = 1'b0, spec_clr = 1'b0;
    logic spec_flag;

    always #10 clk = ~clk;

    swflow_ctrl #(.RXQ_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_char(rx_char),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .rxq_level(rxq_level), .rxq_trig(rxq_trig),
        .txd_vld(txd_vld), .txd_data(txd_data), .txd_rdy(txd_rdy),
        .ser_vld(ser_vld), .ser_data(ser_data), .ser_rdy(ser_rdy),
        .cfg_xon1(XON1), .cfg_xon2(XON2), .cfg_xoff1(XOFF1), .cfg_xoff2(XOFF2),
        .rx_mode(rx_mode), .tx_mode(tx_mode),
        .spec_en(spec_en), .spec_clr(spec_clr), .spec_flag(spec_flag)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [7:0] got_q[$], exp_q[$], ser_q[$];
    logic take = 1'b0;
    logic [6:0] cnt = '0;
    bit rnd_rdy = 0, fix_rdy = 1;

    // Reference model state
    int m_mode = 0;
    bit m_spec = 0, m_paused = 0, m_hold = 0, m_hold_go = 0, m_flag = 0;
    logic [7:0] m_hold_ch = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitors sample mid-cycle, away from the active edge.
    always @(negedge clk) begin
        take = txd_vld && txd_rdy;
        if (fifo_wr) got_q.push_back(fifo_wdata);
        if (ser_vld && ser_rdy) ser_q.push_back(ser_data);
    end

    // Data source and serializer model, driven 2 ns after the edge.
    always @(posedge clk) begin
        #2;
        if (take) cnt = cnt + 7'd1;
        txd_data = {1'b0, cnt};
        ser_rdy  = rnd_rdy ? 1'($urandom % 2) : fix_rdy;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #4; end
    endtask

    task automatic model_rx(input logic [7:0] c);
        bit sp, done;
        sp = m_spec && (c == XOFF2);
        if (sp) m_flag = 1;
        done = 0;
        if (m_mode == 0) exp_q.push_back(c);
        else if (m_mode == 1 || m_mode == 2) begin
            if (!sp && c == (m_mode == 1 ? XOFF1 : XOFF2)) m_paused = 1;
            else if (!sp && c == (m_mode == 1 ? XON1 : XON2)) m_paused = 0;
            else exp_q.push_back(c);
        end else begin
            if (m_hold) begin
                if (!sp && !m_hold_go && c == XOFF2) begin m_paused = 1; m_hold = 0; done = 1; end
                else if (!sp && m_hold_go && c == XON2) begin m_paused = 0; m_hold = 0; done = 1; end
                else begin exp_q.push_back(m_hold_ch); m_hold = 0; end
            end
            if (!done) begin
                if (!sp && c == XOFF1) begin m_hold = 1; m_hold_go = 0; m_hold_ch = c; end
                else if (!sp && c == XON1) begin m_hold = 1; m_hold_go = 1; m_hold_ch = c; end
                else exp_q.push_back(c);
            end
        end
    endtask

    task automatic set_rx(input int m, input bit s);
        @(posedge clk); #4;
        rx_mode = 2'(m); spec_en = s;
        m_mode = m; m_spec = s;
        if (m != 3) m_hold = 0;
        if (m == 0) m_paused = 0;
        idle(2);
    endtask

    // One character: strobe, then three quiet cycles; pause and flag checked after.
    task automatic send_rx(input logic [7:0] c, input string req);
        @(posedge clk); #4;
        rx_vld = 1; rx_char = c;
        @(posedge clk); #4;
        rx_vld = 0;
        model_rx(c);
        idle(2);
        chk(txd_rdy == !m_paused, req, txd_rdy, !m_paused);
        chk(spec_flag == m_flag, {req, " R6 flag"}, spec_flag, m_flag);
    endtask

    task automatic cmp_fifo(input string req);
        int bad = -1;
        if (got_q.size() == exp_q.size())
            foreach (exp_q[i]) if (bad < 0 && got_q[i] != exp_q[i]) bad = i;
        chk(got_q.size() == exp_q.size() && bad < 0, req,
            (bad < 0) ? got_q.size() : got_q[bad], (bad < 0) ? exp_q.size() : exp_q[bad]);
        got_q.delete(); exp_q.delete();
    endtask

    function automatic logic [7:0] rnd_char();
        int r = $urandom % 8;
        case (r)
            0: return XON1;
            1: return XON2;
            2: return XOFF1;
            3: return XOFF2;
            default: return 8'($urandom % 128);
        endcase
    endfunction

    function automatic int cnt_val(input logic [7:0] v);
        int n = 0;
        foreach (ser_q[i]) if (ser_q[i] == v) n++;
        return n;
    endfunction

    function automatic int n_data();
        int n = 0;
        foreach (ser_q[i]) if (ser_q[i] < 8'h80) n++;
        return n;
    endfunction

    function automatic bit contig();
        logic [7:0] prev = '0;
        bit have = 0;
        foreach (ser_q[i]) if (ser_q[i] < 8'h80) begin
            if (have && ser_q[i] != ((prev + 8'd1) & 8'h7f)) return 0;
            prev = ser_q[i]; have = 1;
        end
        return 1;
    endfunction

    function automatic bit pair_ok(input logic [7:0] a, input logic [7:0] b);
        foreach (ser_q[i]) if (ser_q[i] == a) return (i + 1 < ser_q.size()) && (ser_q[i+1] == b);
        return 0;
    endfunction

    initial begin
        void'($urandom(32'h5eed));
        idle(3);
        rst = 0;
        @(posedge clk); #4;
        // R1 reset state
        chk(fifo_wr == 0, "R1 fifo_wr", fifo_wr, 0);
        chk(spec_flag == 0, "R1 spec_flag", spec_flag, 0);
        chk(ser_vld == 1 && ser_data == txd_data, "R1 pass-through", ser_data, txd_data);
        chk(txd_rdy == ser_rdy, "R1 txd_rdy", txd_rdy, ser_rdy);

        // R11 receive off: everything stored; transmit off: nothing inserted
        rxq_trig = LW'(3); rxq_level = LW'(DEPTH);
        ser_q.delete();
        for (int i = 0; i < 20; i++) send_rx(rnd_char(), "R11 rx off");
        cmp_fifo("R11 R5 all stored in order");
        chk(n_data() == ser_q.size(), "R11 no insertion", ser_q.size() - n_data(), 0);
        rxq_level = '0; rxq_trig = '0;

        // R2 R3 R4 R5: random streams in each matching mode
        for (int m = 1; m <= 3; m++) begin
            set_rx(m, 0);
            for (int i = 0; i < 30; i++) send_rx(rnd_char(), "R2 R3 R4 pause state");
            cmp_fifo("R5 stored stream");
        end

        // R4 directed dual cases
        set_rx(3, 0);
        send_rx(XOFF1, "R4"); send_rx(XOFF2, "R4 pair pauses");
        send_rx(XON1, "R4"); send_rx(8'h05, "R4 broken go pair");
        send_rx(XON1, "R4"); send_rx(XON2, "R4 pair resumes");
        send_rx(XOFF1, "R4"); send_rx(XOFF1, "R4"); send_rx(XOFF2, "R4 repeated first");
        send_rx(XON1, "R4"); send_rx(XON2, "R4 resume");
        cmp_fifo("R4 R5 dual storage order");

        // R6 special detect, random dual stream with detect on
        set_rx(2, 1);
        send_rx(XOFF2, "R6 stored not paused");
        @(posedge clk); #4; spec_clr = 1;
        @(posedge clk); #4; spec_clr = 0; m_flag = 0;
        #1 chk(spec_flag == 0, "R6 clear", spec_flag, 0);
        set_rx(1, 1);
        send_rx(XOFF2, "R6 single set one");
        set_rx(3, 1);
        for (int i = 0; i < 30; i++) send_rx(rnd_char(), "R6 R4 dual with detect");
        cmp_fifo("R6 stored stream");
        @(posedge clk); #4; spec_clr = 1;
        @(posedge clk); #4; spec_clr = 0; m_flag = 0;
        set_rx(0, 0);

        // Insertion: R8 R7 R9 R10
        tx_mode = 2'd1; rxq_trig = LW'(8); rxq_level = LW'(5); rnd_rdy = 1;
        idle(2); ser_q.delete(); idle(20);
        chk(n_data() == ser_q.size(), "R8 no go without stop", ser_q.size() - n_data(), 0);
        rxq_level = LW'(8); ser_q.delete(); idle(30);
        chk(n_data() == ser_q.size(), "R7 level equal", ser_q.size() - n_data(), 0);
        rxq_level = LW'(9); ser_q.delete(); idle(30);
        chk(cnt_val(XOFF1) == 1 && ser_q.size() == n_data() + 1, "R7 stop once", cnt_val(XOFF1), 1);
        chk(contig(), "R9 data continuity", 0, 1);
        rxq_level = LW'(8); ser_q.delete(); idle(20);
        chk(n_data() == ser_q.size(), "R8 equal no go", ser_q.size() - n_data(), 0);
        rxq_level = LW'(7); ser_q.delete(); idle(30);
        chk(cnt_val(XON1) == 1 && ser_q.size() == n_data() + 1, "R8 go once", cnt_val(XON1), 1);
        chk(contig(), "R9 data continuity", 0, 1);

        // R10 dual insertion
        @(posedge clk); #4; tx_mode = 2'd3; rxq_level = LW'(9);
        ser_q.delete(); idle(30);
        chk(pair_ok(XOFF1, XOFF2), "R10 stop pair", cnt_val(XOFF2), 1);
        rxq_level = LW'(7); ser_q.delete(); idle(30);
        chk(pair_ok(XON1, XON2), "R10 go pair", cnt_val(XON2), 1);
        chk(contig(), "R9 data continuity dual", 0, 1);

        // R9 hold while serializer busy
        rnd_rdy = 0; fix_rdy = 0; idle(2);
        tx_mode = 2'd2; rxq_level = LW'(9); idle(4);
        chk(ser_vld && ser_data == XOFF2, "R9 held insert", ser_data, XOFF2);
        chk(txd_rdy == 0, "R9 data blocked", txd_rdy, 0);
        ser_q.delete(); fix_rdy = 1; idle(4);
        chk(cnt_val(XOFF2) == 1, "R9 insert accepted once", cnt_val(XOFF2), 1);
        chk(txd_rdy == 1, "R9 data resumes", txd_rdy, 1);

        // R12 insertion while paused, then R3 resume
        set_rx(1, 0);
        send_rx(XOFF1, "R2 pause");
        ser_q.delete(); rxq_level = LW'(7); idle(20);
        chk(cnt_val(XON2) == 1 && n_data() == 0, "R12 go sent while paused", ser_q.size(), 1);
        send_rx(XON1, "R3 resume");
        cmp_fifo("R2 R3 codes not stored");

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule